// File: doc/BRIEF.md
# Transceiver Tuning Word Generator

This block turns a carrier frequency, given in hertz, into the three frequency-setting bytes of a sub-GHz radio transceiver. It then writes those bytes to the radio in one SPI burst. A start strobe captures the requested frequency. Frequencies at or above 480 MHz are first halved and flagged as high band. The result is divided by a programmable reference frequency, which resets to 10 MHz. The integer quotient becomes a biased band index. The remainder is scaled into a carrier word with a step of 156.25 Hz.

Both divisions run one after the other on a single restoring divider that yields one quotient bit per clock. When the carrier word is known, the block lowers chip select and shifts out 32 bits in SPI mode 0: a write-marked address byte, then the band byte, the carrier high byte and the carrier low byte. The radio advances its register address by itself between the data bytes. A single-cycle done pulse ends the operation. A sticky changed flag tells the surrounding logic that a new tuning word has been loaded.

Top module: `tuning_word_gen`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sclk, busy, done and freq_changed are 0.
- R2: A requested frequency of 480,000,000 or more sets the high-band bit (band byte bit 5) to 1 and is halved (integer floor) before any division. A lower frequency leaves bit 5 at 0 and is used unchanged.
- R3: The band index N is the integer quotient of the (possibly halved) frequency divided by the reference. The band byte carries (N minus 24) modulo 32 in bits 4:0, a fixed 1 in bit 6 and 0 in bit 7.
- R4: The carrier word is floor(4 × remainder / 625), kept to 16 bits, where remainder = frequency − N × reference. Its high byte is sent before its low byte.
- R5: Each conversion produces exactly one chip-select-low period of 32 bits, sent MSB first in this order: 0xF5 (register address 0x75 with bit 7 set for write), band byte, carrier high byte, carrier low byte.
- R6: The SPI runs in mode 0. spi_sclk is low whenever chip select is high, spi_mosi never changes on a cycle where spi_sclk rises, and a frame holds exactly 32 rising clock edges.
- R7: A start pulse that arrives while busy is high is ignored. It produces no extra frame and does not change the frame in flight.
- R8: busy rises on the cycle after an accepted start and falls on the same cycle that done pulses. done lasts exactly one cycle, and chip select is already high when it occurs.
- R9: freq_changed goes to 1 with done and returns to 0 when the next start is accepted.
- R10: The reference register resets to 10,000,000. A write with ref_we while idle loads ref_data and is used by conversions that start on later cycles. A write while busy is ignored.
- R11: A reference write with ref_data equal to 0 is ignored, and the previous reference is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request strobe, sampled when idle |
| freq_hz | input | 32 | Requested carrier frequency in hertz |
| ref_we | input | 1 | Reference register write enable |
| ref_data | input | 32 | New reference frequency in hertz |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI serial data to the radio |
| spi_cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | Conversion or transfer in progress |
| done | output | 1 | One-cycle end-of-write pulse |
| freq_changed | output | 1 | Set when a tuning word has been written, cleared by the next start |

## Verification
The main function is swept over every band index on both sides of the 480 MHz split. Each index is tried at four offsets: exactly on a reference multiple, one hertz above it, one hertz below the next multiple, and a scattered value. Together these separate the halving, the bias of 24, the truncation of the carrier word and the byte order. The frequencies 479,999,999, 480,000,000 and 480,000,001 probe the band boundary and the floor in the halving. A 26 MHz reference checks that the programmed divisor is used. Starts and reference writes issued mid-operation, plus a zero reference write, check the ignore rules at the pins.

// File: rtl/tuneword_pkg.sv
package tuneword_pkg;

    typedef enum logic [1:0] {
        TW_IDLE,
        TW_BAND,
        TW_CARR,
        TW_SEND
    } tw_state_e;

    localparam int unsigned TW_HIGH_LIMIT = 32'd480_000_000;
    localparam int unsigned TW_REF_RESET  = 32'd10_000_000;
    localparam int unsigned TW_STEP_MUL   = 4;
    localparam int unsigned TW_STEP_DIV   = 625;
    localparam logic [4:0]  TW_BAND_BIAS  = 5'd24;
    localparam logic [6:0]  TW_REG_ADDR   = 7'h75;
    localparam logic        TW_SIDE_SEL   = 1'b1;

endpackage

// File: rtl/tw_restoring_div.sv
module tw_restoring_div #(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
        logic [CW-1:0] cnt;
        logic          run;
        logic          valid;
    } div_st_t;

    div_st_t st_q, st_d;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        shifted    = {st_q.rem, st_q.quo[W-1]};
        trial      = shifted - {1'b0, st_q.den};
        if (go) begin
            st_d.rem = '0;
            st_d.quo = dividend;
            st_d.den = divisor;
            st_d.cnt = CW'(W);
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            if (shifted >= {1'b0, st_q.den}) begin
                st_d.rem = trial[W-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b1};
            end else begin
                st_d.rem = shifted[W-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.run   = 1'b0;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid     = st_q.valid;
    assign quotient  = st_q.quo;
    assign remainder = st_q.rem;

endmodule

// File: rtl/tw_spi_burst.sv
module tw_spi_burst #(
    parameter int FRAME_W = 32,
    parameter int HALF    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FRAME_W-1:0] frame,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               fin
);
    localparam int BW = $clog2(FRAME_W);
    localparam int TW = $clog2(HALF) + 1;

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [BW-1:0]      bits;
        logic [TW-1:0]      tick;
        logic               sclk;
        logic               cs_n;
        logic               fin;
    } spi_st_t;

    spi_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        if (st_q.cs_n) begin
            if (go) begin
                st_d.cs_n = 1'b0;
                st_d.sclk = 1'b0;
                st_d.sh   = frame;
                st_d.bits = '0;
                st_d.tick = '0;
            end
        end else begin
            st_d.tick = st_q.tick + TW'(1);
            if (st_q.tick == TW'(HALF - 1)) begin
                st_d.tick = '0;
                if (!st_q.sclk) begin
                    st_d.sclk = 1'b1;
                end else begin
                    st_d.sclk = 1'b0;
                    if (st_q.bits == BW'(FRAME_W - 1)) begin
                        st_d.cs_n = 1'b1;
                        st_d.fin  = 1'b1;
                    end else begin
                        st_d.bits = st_q.bits + BW'(1);
                        st_d.sh   = {st_q.sh[FRAME_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.sclk;
    assign mosi = st_q.sh[FRAME_W-1];
    assign cs_n = st_q.cs_n;
    assign fin  = st_q.fin;

endmodule

// File: rtl/tuning_word_gen.sv
module tuning_word_gen #(
    parameter int FREQ_W   = 32,
    parameter int SPI_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_hz,
    input  logic              ref_we,
    input  logic [FREQ_W-1:0] ref_data,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              busy,
    output logic              done,
    output logic              freq_changed
);
    import tuneword_pkg::*;

    localparam int DIV_W   = FREQ_W + 2;
    localparam int FRAME_W = 32;

    typedef struct packed {
        tw_state_e         state;
        logic [FREQ_W-1:0] refv;
        logic              hb;
        logic [4:0]        band;
        logic              busy;
        logic              done;
        logic              chg;
    } top_st_t;

    top_st_t st_q, st_d;

    logic               div_go;
    logic [DIV_W-1:0]   div_num;
    logic [DIV_W-1:0]   div_den;
    logic               div_valid;
    logic [DIV_W-1:0]   div_quo;
    logic [DIV_W-1:0]   div_rem;
    logic               spi_go;
    logic [FRAME_W-1:0] spi_frame;
    logic               spi_fin;
    logic               high_req;
    logic [FREQ_W-1:0]  scaled_freq;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        div_go      = 1'b0;
        div_num     = '0;
        div_den     = DIV_W'(TW_STEP_DIV);
        spi_go      = 1'b0;
        high_req    = (freq_hz >= FREQ_W'(TW_HIGH_LIMIT));
        scaled_freq = high_req ? (freq_hz >> 1) : freq_hz;
        spi_frame   = {1'b1, TW_REG_ADDR, 1'b0, TW_SIDE_SEL, st_q.hb, st_q.band,
                       div_quo[15:0]};
        unique case (st_q.state)
            TW_IDLE: begin
                if (ref_we && (ref_data != '0)) st_d.refv = ref_data;
                if (start) begin
                    st_d.hb    = high_req;
                    div_go     = 1'b1;
                    div_num    = DIV_W'(scaled_freq);
                    div_den    = DIV_W'(st_q.refv);
                    st_d.busy  = 1'b1;
                    st_d.chg   = 1'b0;
                    st_d.state = TW_BAND;
                end
            end
            TW_BAND: begin
                if (div_valid) begin
                    st_d.band  = div_quo[4:0] - TW_BAND_BIAS;
                    div_go     = 1'b1;
                    div_num    = {div_rem[FREQ_W-1:0], 2'b00};
                    st_d.state = TW_CARR;
                end
            end
            TW_CARR: begin
                if (div_valid) begin
                    spi_go     = 1'b1;
                    st_d.state = TW_SEND;
                end
            end
            TW_SEND: begin
                if (spi_fin) begin
                    st_d.busy  = 1'b0;
                    st_d.done  = 1'b1;
                    st_d.chg   = 1'b1;
                    st_d.state = TW_IDLE;
                end
            end
            default: st_d.state = TW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.refv <= FREQ_W'(TW_REF_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    tw_restoring_div #(.W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (div_go),
        .dividend  (div_num),
        .divisor   (div_den),
        .valid     (div_valid),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    tw_spi_burst #(.FRAME_W(FRAME_W), .HALF(SPI_HALF)) u_spi (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (spi_go),
        .frame (spi_frame),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n),
        .fin   (spi_fin)
    );

    assign busy         = st_q.busy;
    assign done         = st_q.done;
    assign freq_changed = st_q.chg;

endmodule

// File: rtl/tw_checker.sv
module tw_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic freq_changed,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n
);
    // R6: clock idles low outside a frame
    a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R6: data is settled when the clock rises
    a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    // R8: done closes the operation with chip select released
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && spi_cs_n));

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a frame only occurs inside a busy operation
    a_r5_cs_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R9: flag is set together with done
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> freq_changed);

    // R9: flag is cleared as a new operation begins
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !freq_changed);

    // R7: a start while busy does not end the operation early
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !spi_cs_n) |=> busy);
endmodule

bind tuning_word_gen tw_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .freq_changed (freq_changed),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .spi_cs_n     (spi_cs_n)
);

// File: tb/tuning_word_gen_test.sv
module tuning_word_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] freq_hz = '0;
    logic        ref_we = 1'b0;
    logic [31:0] ref_data = '0;
    logic        spi_sclk, spi_mosi, spi_cs_n, busy, done, freq_changed;

    int n_checks = 0;
    int n_fail   = 0;
    int frames   = 0;
    int mon_bits = 0;
    logic [31:0] mon_frame = '0;
    int cycles   = 0;

    tuning_word_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_hz(freq_hz),
        .ref_we(ref_we), .ref_data(ref_data), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .busy(busy), .done(done),
        .freq_changed(freq_changed)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge spi_cs_n) begin
        mon_bits  = 0;
        mon_frame = '0;
    end
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        mon_frame = {mon_frame[30:0], spi_mosi};
        mon_bits  = mon_bits + 1;
    end
    always @(posedge spi_cs_n) frames = frames + 1;

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 190000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R2 R3 R4 R5: expected burst computed from the arithmetic rules
    function automatic logic [31:0] exp_frame(input longint f, input longint rf);
        longint g, n, r, c;
        logic hb;
        logic [4:0] nb;
        hb = (f >= 64'd480000000);
        g  = hb ? f / 2 : f;
        n  = g / rf;
        r  = g - n * rf;
        c  = (4 * r) / 625;
        nb = 5'(n - 24);
        return {8'hF5, 1'b0, 1'b1, hb, nb, 16'(c)};
    endfunction

    task automatic convert(input longint f, input longint rf, input bit inject,
                           input bit ref_poke);
        int f0;
        bit seen;
        logic [31:0] want;
        want = exp_frame(f, rf);
        f0 = frames;
        @(negedge clk);
        freq_hz = 32'(f);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", longint'(busy), 1);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (inject && i == 20) begin
                start   = 1'b1;
                freq_hz = 32'(f + 64'd12345678);
            end
            if (inject && i == 21) start = 1'b0;
            if (ref_poke && i == 30) begin
                ref_we   = 1'b1;
                ref_data = 32'd5000000;
            end
            if (ref_poke && i == 31) ref_we = 1'b0;
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
        check(seen, "R8 done seen", longint'(seen), 1);
        check(mon_frame == want, "R5 R2 R3 R4 frame", longint'(mon_frame), longint'(want));
        check(mon_bits == 32 && frames == f0 + 1, "R6 one 32-bit frame",
              longint'(mon_bits), 32);
        check(!busy && spi_cs_n && !spi_sclk, "R8 idle at done", longint'(busy), 0);
        check(freq_changed == 1'b1, "R9 flag set", longint'(freq_changed), 1);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", longint'(done), 0);
    endtask

    initial begin
        longint rf;
        int f_before;
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sclk && !busy && !done && !freq_changed,
              "R1 reset state", longint'({spi_cs_n, spi_sclk, busy, done, freq_changed}),
              longint'(5'b10000));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4: every band index, both bands, four offsets, default reference (R10)
        rf = 10000000;
        for (int k = 0; k < 48; k++) begin
            for (int o = 0; o < 4; o++) begin
                longint n, off, f;
                n   = 24 + (k % 24);
                off = (o == 0) ? 0 : (o == 1) ? 1 : (o == 2) ? rf - 1 :
                      (longint'(k) * 123457 + 5) % rf;
                f   = n * rf + off;
                if (k >= 24) f = 2 * f + (k & 1);
                convert(f, rf, 1'b0, 1'b0);
            end
        end

        // R2: band boundary and floor of the halving
        convert(64'd479999999, rf, 1'b0, 1'b0);
        convert(64'd480000000, rf, 1'b0, 1'b0);
        convert(64'd480000001, rf, 1'b0, 1'b0);

        // R9: flag clears when the next start is accepted
        @(negedge clk);
        freq_hz = 32'd433920000;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(freq_changed == 1'b0, "R9 flag cleared on start", longint'(freq_changed), 0);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        check(mon_frame == exp_frame(64'd433920000, rf), "R9 frame after clear",
              longint'(mon_frame), longint'(exp_frame(64'd433920000, rf)));

        // R7: second start during the operation is ignored
        f_before = frames;
        convert(64'd315000000, rf, 1'b1, 1'b0);
        repeat (400) @(negedge clk);
        check(frames == f_before + 1 && spi_cs_n, "R7 no extra frame",
              longint'(frames - f_before), 1);

        // R10: programmed reference is used
        @(negedge clk);
        ref_we   = 1'b1;
        ref_data = 32'd26000000;
        @(negedge clk);
        ref_we = 1'b0;
        rf = 26000000;
        convert(64'd868300000, rf, 1'b0, 1'b0);
        convert(64'd433920000, rf, 1'b0, 1'b0);

        // R10: write while busy is ignored, next conversion keeps 26 MHz
        convert(64'd700000000, rf, 1'b0, 1'b1);
        convert(64'd700000000, rf, 1'b0, 1'b0);

        // R11: zero reference write is ignored
        @(negedge clk);
        ref_we   = 1'b1;
        ref_data = 32'd0;
        @(negedge clk);
        ref_we = 1'b0;
        convert(64'd915000000, rf, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule